// File: doc/BRIEF.md
# Triangular Spread-Spectrum Fractional Divide Word Generator

This block sits in front of a fractional-N PLL feedback divider and delivers the divide word that the divider's quantizer consumes. Software programs a start value, an 8-bit integer part and an 18-bit fraction, and the block holds the word at that value until modulation is switched on. With modulation on, the word follows a triangle around the start value. It moves by one programmed step every (adjust period + 1) reference ticks and changes ramp direction at the end of every half period. Software trims the half period to a whole number of adjustment intervals.

Two spread shapes are available. Down-spread keeps the word at or below the start value. Center-spread starts the phase counter midway, so the triangle swings roughly equally above and below the start value. The result saturates at zero and at the all-ones word instead of wrapping. The word is registered and changes only on a reference tick. Removing the enable restores the start value on the next tick.

Top module: `ssc_fracn_mod`

## Requirements
- R1: With modulation disabled, each reference tick loads the output with the start word. Bits 25:18 hold the integer byte, bits 17:16 the fraction high field, bits 15:8 the fraction mid byte and bits 7:0 the fraction low byte. In `ssc_ctrl`, bit 1 enables modulation and bit 0 selects center spread. Each 16-bit field (half period, step, adjust period) is formed as {high byte, low byte}.
- R2: During and directly after reset, the output word is zero.
- R3: The output word changes only on cycles in which `ref_tick` is high.
- R4: If the enable is low at a tick, the word returns to the start word at that tick, whatever ramp state came before.
- R5: The first tick with the enable high starts modulation with zero offset. That tick outputs the start word and takes no step.
- R6: Once running, the offset moves by exactly one step on every (adjust period + 1)-th tick and holds on all other ticks. The adjustment count restarts at each direction change.
- R7: In down-spread, the offset falls for (half period + 1) ticks, then rises for the same number of ticks, and the cycle repeats. With an aligned half period of K·(adjust period + 1) − 1, the lowest word is start − K·step, the highest word is the start word, and successive minima lie 2·(half period + 1) ticks apart.
- R8: Center spread is sampled when modulation starts. The phase counter is preloaded to floor((half period + 1)/2) and the ramp starts downward. With K even, the word therefore spans start ± (K/2)·step.
- R9: Below zero the word saturates at 0, and above 2^26 − 1 it saturates at 2^26 − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| int_start | input | 8 | Integer part of the start word |
| frac_lo | input | 8 | Fraction bits 7:0 |
| frac_mid | input | 8 | Fraction bits 15:8 |
| frac_hi | input | 2 | Fraction bits 17:16 |
| half_lo | input | 8 | Half-period count, low byte |
| half_hi | input | 8 | Half-period count, high byte |
| step_lo | input | 8 | Step size, low byte |
| step_hi | input | 8 | Step size, high byte |
| adjp_lo | input | 8 | Adjust period, low byte |
| adjp_hi | input | 8 | Adjust period, high byte |
| ssc_ctrl | input | 2 | Bit 1 modulation enable, bit 0 center spread |
| div_word | output | 26 | Current divide word |

## Verification
A wrong adjustment or phase count appears at the port within one adjustment interval. The step then lands on the wrong tick, or the turn comes early or late, and the difference between word and model keeps growing for the rest of the half period. A wrong accumulator or direction state shows up as a wrong peak or a wrong spacing of the minima within one triangle period. A stale offset after disable shows up on the very next tick, because the word must then equal the start value.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   typedef enum logic {
      RAMP_DN = 1'b0,
      RAMP_UP = 1'b1
   } ramp_dir_e;
endpackage

// File: rtl/ssc_tick_seq.sv
module ssc_tick_seq
   import ssc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             center,
   input  logic [CNT_W-1:0] half_per,
   input  logic [CNT_W-1:0] adj_per,
   output logic             step_now,
   output ramp_dir_e        dir,
   output logic             run
);
   logic [CNT_W-1:0] adj_q;
   logic [CNT_W-1:0] ph_q;
   logic [CNT_W:0]   hp_p1;
   logic [CNT_W-1:0] ph_mid;

   assign hp_p1  = {1'b0, half_per} + (CNT_W+1)'(1);
   assign ph_mid = hp_p1[CNT_W:1];

   assign step_now = tick && en && run && (adj_q == adj_per);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adj_q <= '0;
         ph_q  <= '0;
         dir   <= RAMP_DN;
         run   <= 1'b0;
      end else if (tick) begin
         if (!en) begin
            adj_q <= '0;
            ph_q  <= '0;
            dir   <= RAMP_DN;
            run   <= 1'b0;
         end else if (!run) begin
            run   <= 1'b1;
            adj_q <= '0;
            dir   <= RAMP_DN;
            ph_q  <= center ? ph_mid : '0;
         end else begin
            if (ph_q == half_per) begin
               ph_q  <= '0;
               adj_q <= '0;
               dir   <= (dir == RAMP_DN) ? RAMP_UP : RAMP_DN;
            end else begin
               ph_q  <= ph_q + CNT_W'(1);
               adj_q <= (adj_q == adj_per) ? '0 : adj_q + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/ssc_ramp_acc.sv
module ssc_ramp_acc
   import ssc_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int OFF_W = 34
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    en,
   input  logic                    run,
   input  logic                    step_now,
   input  ramp_dir_e               dir,
   input  logic [CNT_W-1:0]        step,
   output logic signed [OFF_W-1:0] off_q,
   output logic signed [OFF_W-1:0] off_d
);
   logic signed [OFF_W-1:0] step_s;

   assign step_s = signed'({{(OFF_W-CNT_W){1'b0}}, step});

   always_comb begin
      off_d = off_q;
      if (tick) begin
         if (!en || !run)
            off_d = '0;
         else if (step_now)
            off_d = (dir == RAMP_DN) ? off_q - step_s : off_q + step_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) off_q <= '0;
      else        off_q <= off_d;
   end
endmodule

// File: rtl/ssc_word_out.sv
module ssc_word_out #(
   parameter int WORD_W   = 26,
   parameter int OFF_W    = 34,
   parameter bit SATURATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic [WORD_W-1:0]       base,
   input  logic signed [OFF_W-1:0] off_d,
   output logic [WORD_W-1:0]       word
);
   localparam int SUM_W = OFF_W + 1;
   localparam logic signed [SUM_W-1:0] MAXV =
      {{(SUM_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};

   logic signed [SUM_W-1:0] sum;
   logic [WORD_W-1:0]       next_word;

   assign sum = signed'({{(SUM_W-WORD_W){1'b0}}, base}) + {off_d[OFF_W-1], off_d};

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (sum < 0)         next_word = '0;
            else if (sum > MAXV) next_word = {WORD_W{1'b1}};
            else                 next_word = sum[WORD_W-1:0];
         end
      end else begin : g_wrap
         assign next_word = sum[WORD_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word <= '0;
      else if (tick) word <= next_word;
   end
endmodule

// File: rtl/ssc_fracn_mod.sv
module ssc_fracn_mod
   import ssc_pkg::*;
#(
   parameter int INT_W    = 8,
   parameter int FRAC_W   = 18,
   parameter int BYTE_W   = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ref_tick,
   input  logic [INT_W-1:0]           int_start,
   input  logic [BYTE_W-1:0]          frac_lo,
   input  logic [BYTE_W-1:0]          frac_mid,
   input  logic [FRAC_W-2*BYTE_W-1:0] frac_hi,
   input  logic [BYTE_W-1:0]          half_lo,
   input  logic [BYTE_W-1:0]          half_hi,
   input  logic [BYTE_W-1:0]          step_lo,
   input  logic [BYTE_W-1:0]          step_hi,
   input  logic [BYTE_W-1:0]          adjp_lo,
   input  logic [BYTE_W-1:0]          adjp_hi,
   input  logic [1:0]                 ssc_ctrl,
   output logic [INT_W+FRAC_W-1:0]    div_word
);
   localparam int WORD_W = INT_W + FRAC_W;
   localparam int CNT_W  = 2 * BYTE_W;
   localparam int OFF_W  = 2 * CNT_W + 2;

   generate
      if (FRAC_W <= 2 * BYTE_W || FRAC_W > 3 * BYTE_W) begin : g_bad_frac
         $error("FRAC_W must exceed two bytes and fit in three");
      end
      if (WORD_W >= OFF_W) begin : g_bad_off
         $error("offset accumulator narrower than the word");
      end
   endgenerate

   logic [WORD_W-1:0]       base;
   logic [CNT_W-1:0]        half_per, step, adj_per;
   logic                    en, center;
   logic                    step_now, seq_run;
   ramp_dir_e               dir;
   logic signed [OFF_W-1:0] ramp_off, ramp_off_d;

   assign base     = {int_start, frac_hi, frac_mid, frac_lo};
   assign half_per = {half_hi, half_lo};
   assign step     = {step_hi, step_lo};
   assign adj_per  = {adjp_hi, adjp_lo};
   assign en       = ssc_ctrl[1];
   assign center   = ssc_ctrl[0];

   ssc_tick_seq #(.CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (ref_tick),
      .en       (en),
      .center   (center),
      .half_per (half_per),
      .adj_per  (adj_per),
      .step_now (step_now),
      .dir      (dir),
      .run      (seq_run)
   );

   ssc_ramp_acc #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (ref_tick),
      .en       (en),
      .run      (seq_run),
      .step_now (step_now),
      .dir      (dir),
      .step     (step),
      .off_q    (ramp_off),
      .off_d    (ramp_off_d)
   );

   ssc_word_out #(.WORD_W(WORD_W), .OFF_W(OFF_W), .SATURATE(SATURATE)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (ref_tick),
      .base  (base),
      .off_d (ramp_off_d),
      .word  (div_word)
   );
endmodule

// File: rtl/ssc_fracn_mod_chk.sv
module ssc_fracn_mod_chk #(
   parameter int WORD_W = 26,
   parameter int CNT_W  = 16,
   parameter int OFF_W  = 34
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    ref_tick,
   input logic                    en,
   input logic                    run,
   input logic [WORD_W-1:0]       base,
   input logic [CNT_W-1:0]        step,
   input logic [WORD_W-1:0]       word,
   input logic signed [OFF_W-1:0] off
);
   logic signed [OFF_W-1:0] step_w;
   assign step_w = signed'({{(OFF_W-CNT_W){1'b0}}, step});

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_tick |=> $stable(word));

   // R4
   disable_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_tick && !en) |=> (word == $past(base)));

   // R5
   start_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_tick && en && !run) |=> (word == $past(base) && off == 0));

   // R6
   step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_tick && en && run) |=>
         (off == $past(off) || off == $past(off) + $past(step_w)
          || off == $past(off) - $past(step_w)));
endmodule

bind ssc_fracn_mod ssc_fracn_mod_chk #(
   .WORD_W (WORD_W),
   .CNT_W  (CNT_W),
   .OFF_W  (OFF_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ref_tick (ref_tick),
   .en       (en),
   .run      (seq_run),
   .base     (base),
   .step     (step),
   .word     (div_word),
   .off      (ramp_off)
);

// File: tb/sim_ssc_fracn_mod.sv
`timescale 1ns/1ps
module sim_ssc_fracn_mod;
   localparam longint WMAX = (64'd1 << 26) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic [7:0]  int_start = '0, frac_lo = '0, frac_mid = '0;
   logic [1:0]  frac_hi = '0;
   logic [7:0]  half_lo = '0, half_hi = '0, step_lo = '0, step_hi = '0;
   logic [7:0]  adjp_lo = '0, adjp_hi = '0;
   logic [1:0]  ssc_ctrl = '0;
   logic [25:0] div_word;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   longint m_off, m_ph, m_adj, m_word;
   bit     m_dir, m_run;

   always #4 clk = ~clk;

   ssc_fracn_mod u0 (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .int_start(int_start), .frac_lo(frac_lo), .frac_mid(frac_mid), .frac_hi(frac_hi),
      .half_lo(half_lo), .half_hi(half_hi), .step_lo(step_lo), .step_hi(step_hi),
      .adjp_lo(adjp_lo), .adjp_hi(adjp_hi), .ssc_ctrl(ssc_ctrl), .div_word(div_word)
   );

   function automatic longint base_val();
      return (longint'(int_start) << 18) | (longint'(frac_hi) << 16)
           | (longint'(frac_mid) << 8) | longint'(frac_lo);
   endfunction

   function automatic longint sat(longint v);
      if (v < 0) return 0;
      if (v > WMAX) return WMAX;
      return v;
   endfunction

   task automatic check(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_cfg(longint b, longint hp, longint st, longint ap, bit cen);
      {int_start, frac_hi, frac_mid, frac_lo} = b[25:0];
      {half_hi, half_lo} = hp[15:0];
      {step_hi, step_lo} = st[15:0];
      {adjp_hi, adjp_lo} = ap[15:0];
      ssc_ctrl[0] = cen;
   endtask

   task automatic model_tick();
      longint hp = {half_hi, half_lo};
      longint ap = {adjp_hi, adjp_lo};
      longint st = {step_hi, step_lo};
      if (!ssc_ctrl[1]) begin
         m_off = 0; m_run = 0; m_adj = 0; m_ph = 0; m_dir = 0;
      end else if (!m_run) begin
         m_run = 1; m_off = 0; m_adj = 0; m_dir = 0;
         m_ph = ssc_ctrl[0] ? (hp + 1) / 2 : 0;
      end else begin
         if (m_adj == ap) m_off = m_dir ? m_off + st : m_off - st;
         if (m_ph == hp) begin
            m_ph = 0; m_dir = !m_dir; m_adj = 0;
         end else begin
            m_ph++;
            m_adj = (m_adj == ap) ? 0 : m_adj + 1;
         end
      end
      m_word = sat(base_val() + m_off);
   endtask

   // R6: every tick is compared with the model
   task automatic do_tick(string req);
      @(negedge clk);
      ref_tick = 1'b1;
      model_tick();
      @(negedge clk);
      ref_tick = 1'b0;
      check(req, div_word, m_word);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
      check("R3", div_word, m_word);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      longint b, mn, mx, first_min, second_min, prev;
      void'($urandom(32'h5eed_2024));
      m_off = 0; m_ph = 0; m_adj = 0; m_dir = 0; m_run = 0; m_word = 0;
      repeat (3) @(negedge clk);
      check("R2", div_word, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2", div_word, 0);

      // R1: field layout while disabled
      int_start = 8'hA5; frac_hi = 2'b10; frac_mid = 8'h3C; frac_lo = 8'h71;
      do_tick("R1");
      check("R1", div_word, (64'hA5 << 18) | (64'h2 << 16) | (64'h3C << 8) | 64'h71);
      idle(3);

      // R7: down-spread, K=4, adj=2, step=7
      b = (64'h40 << 18) | 64'h12345;
      set_cfg(b, 11, 7, 2, 0);
      ssc_ctrl[1] = 1'b1;
      do_tick("R5");
      check("R5", div_word, b);
      mn = b; mx = b; first_min = -1; second_min = -1; prev = b;
      for (int i = 1; i <= 48; i++) begin
         do_tick("R6");
         if (div_word < mn) mn = div_word;
         if (div_word > mx) mx = div_word;
         if (div_word == b - 28 && prev != b - 28) begin
            if (first_min < 0) first_min = i; else if (second_min < 0) second_min = i;
         end
         prev = div_word;
      end
      check("R7", mn, b - 28);
      check("R7", mx, b);
      check("R7", second_min - first_min, 24);
      idle(2);

      // R4: drop enable mid-ramp
      do_tick("R6");
      ssc_ctrl[1] = 1'b0;
      do_tick("R4");
      check("R4", div_word, b);

      // R8: center spread, K=4, step=10
      set_cfg(b, 11, 10, 2, 1);
      ssc_ctrl[1] = 1'b1;
      do_tick("R5");
      mn = b; mx = b;
      for (int i = 0; i < 48; i++) begin
         do_tick("R8");
         if (div_word < mn) mn = div_word;
         if (div_word > mx) mx = div_word;
      end
      check("R8", mn, b - 20);
      check("R8", mx, b + 20);
      ssc_ctrl[1] = 1'b0;
      do_tick("R4");

      // R9: low clamp
      set_cfg(5, 5, 100, 0, 0);
      ssc_ctrl[1] = 1'b1;
      do_tick("R5");
      do_tick("R9");
      check("R9", div_word, 0);
      ssc_ctrl[1] = 1'b0;
      do_tick("R4");

      // R9: high clamp
      set_cfg(WMAX, 5, 100, 0, 1);
      ssc_ctrl[1] = 1'b1;
      do_tick("R5");
      mx = 0;
      for (int i = 0; i < 12; i++) begin
         do_tick("R9");
         if (div_word > mx) mx = div_word;
      end
      check("R9", mx, WMAX);
      check("R9", div_word, WMAX);
      ssc_ctrl[1] = 1'b0;
      do_tick("R4");

      // random configurations, aligned and unaligned
      for (int c = 0; c < 8; c++) begin
         longint k = 1 + $urandom_range(0, 5);
         longint ap = $urandom_range(0, 3);
         longint hp = (c % 4 == 3) ? longint'($urandom_range(0, 20)) : k * (ap + 1) - 1;
         set_cfg({$urandom} & WMAX, hp, $urandom_range(0, 3000), ap, $urandom_range(0, 1));
         ssc_ctrl[1] = 1'b1;
         for (int i = 0; i < 60; i++) begin
            if ($urandom_range(0, 15) == 0) ssc_ctrl[1] = ~ssc_ctrl[1];
            do_tick("R6");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
         end
         ssc_ctrl[1] = 1'b0;
         do_tick("R4");
      end

      done = 1;
      finish_run();
   end
endmodule